// File: doc/BRIEF.md
# Mini-Rank Data Bridge

This block sits between a 64-bit double-data-rate host data bus and private data lanes to each memory device of a rank. It lets one full-width rank of eight devices act as two half-width or four quarter-width mini-ranks. Command and address wires run straight to the devices. The bridge only sees the decoded command. From that command it produces a chip-select enable for each device, and it relays the data of the burst that follows.

One bus cycle carries both edges of the bus. It is modelled as a 128-bit host word (`host_rdq`, `host_wdq`) and as a 16-bit slice per device on the device side. A 64-byte line is four host words on the host side.

On a read, the selected mini-rank streams the line over a longer, narrower burst. The bridge gathers the chunks in a read buffer and releases the four host words so that the last word leaves one cycle after the last device chunk arrives. On a write, the four host words are captured in a separate write buffer and serialized onto the selected lanes over the configured burst length. Reads and writes own separate buffers, so one of each may be in flight together. The split is taken from `cfg_mode` when each command is accepted. A bypass setting relays the full width with a single cycle of delay.

Top module: `mrank_bridge`

## Requirements
- R1: While reset is low, and afterwards until a command is accepted, `host_rvalid`, `host_rdq`, `dev_wen`, `dev_wdq` and `proto_err` are zero. `dev_cs` is zero while `cmd_op` is NOP. A reset in the middle of a burst ends the burst with no further output.
- R2: `cmd_op` encodes 0 = NOP, 1 = activate, 2 = read, 3 = write. A command takes effect only when `cmd_rank` equals `RANK_ID`. A NOP or a command for another rank produces no chip select and starts no burst.
- R3: For an accepted command, `dev_cs` is asserted in the same cycle, and the bits it sets depend on the split:
  - `cfg_mode` 1 (two halves): devices 0-3 when `cmd_mr[0]`=0, devices 4-7 when `cmd_mr[0]`=1.
  - `cfg_mode` 2 (four quarters): devices 2m and 2m+1 for m = `cmd_mr`.
  - `cfg_mode` 0 (bypass) and the unused code 3: all eight devices.
- R4: Counting the command cycle as cycle 0, the read burst from the devices occupies cycles CL to CL+N-1. N is 4 in bypass, 8 for halves and 16 for quarters. In device cycle j, the selected lanes carry line bits [j*S +: S], with lane bits ordered by device index. S is 128, 64 or 32 respectively.
- R5: In half mode, host word k (line bits [k*128 +: 128]) is driven with `host_rvalid` high in cycle CL+5+k. This is 5 cycles later than a direct full-width read.
- R6: In quarter mode, host word k is driven in cycle CL+13+k.
- R7: In bypass, host word k is driven in cycle CL+1+k, exactly one cycle after the device data.
- R8: On a write, host word k is taken from `host_wdq` in cycle CL+k. Device chunk j (line bits [j*S +: S]) is driven on the selected lanes in cycle CL+1+j, for j from 0 to N-1. `dev_wen` marks those devices. All other lane bits are zero.
- R9: A read and a write may overlap in time, including on different mini-ranks, without disturbing each other's data or timing.
- R10: A read arriving while a read is in flight, or a write arriving while a write is in flight, raises `proto_err` in that cycle, gets no chip select and is dropped. The burst in flight is unchanged. A burst is in flight from cycle 1 through cycle CL+N.
- R11: Changing `cfg_mode` during a burst does not alter that burst. The split is latched when the command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mode | input | 2 | Split: 0 bypass, 1 halves, 2 quarters, 3 as bypass |
| cmd_op | input | 2 | Decoded command: NOP, activate, read, write |
| cmd_rank | input | RANK_W | Target rank of the command |
| cmd_mr | input | 2 | Target mini-rank index |
| host_wdq | input | 128 | Host write word (both edges of one cycle) |
| host_rdq | output | 128 | Host read word, zero when not valid |
| host_rvalid | output | 1 | Host read word valid |
| dev_rdq | input | 128 | Device read lanes, 16 bits per device |
| dev_wdq | output | 128 | Device write lanes, 16 bits per device |
| dev_wen | output | 8 | Per-device write lane enable |
| dev_cs | output | 8 | Per-device chip-select enable |
| proto_err | output | 1 | Command refused because its direction is busy |

## Verification
The device model drives a fixed filler on every lane outside the addressed mini-rank. Correct routing is therefore shown by matching host words, while a wrong lane choice or a wrong chunk order shows up as filler or as shuffled words.

Reads and writes are tried in all three splits and for several mini-rank indices, each with a different line pattern. The cycle in which each host word or device chunk appears tells the 5-cycle half latency apart from the 13-cycle quarter latency and the single-cycle bypass.

Directed sequences cover further cases:
- a second command issued while its direction is busy, including on the last beat, and a command issued one cycle after the burst ends;
- a read overlapped with a write;
- a change of split during a burst;
- a reset in the middle of a burst.

// File: rtl/mrank_bridge.sv
module mrank_bridge #(
  parameter int DEV_N = 8,
  parameter int DEV_W = 16,
  parameter int CL = 4,
  parameter int RANK_W = 1,
  parameter logic [RANK_W-1:0] RANK_ID = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             cfg_mode,
  input  logic [1:0]             cmd_op,
  input  logic [RANK_W-1:0]      cmd_rank,
  input  logic [1:0]             cmd_mr,
  input  logic [DEV_N*DEV_W-1:0] host_wdq,
  output logic [DEV_N*DEV_W-1:0] host_rdq,
  output logic                   host_rvalid,
  input  logic [DEV_N*DEV_W-1:0] dev_rdq,
  output logic [DEV_N*DEV_W-1:0] dev_wdq,
  output logic [DEV_N-1:0]       dev_wen,
  output logic [DEV_N-1:0]       dev_cs,
  output logic                   proto_err
);
  localparam int HW  = DEV_N * DEV_W;
  localparam int LW  = 4 * HW;
  localparam int W32 = HW / 2;
  localparam int W16 = HW / 4;
  localparam int D32 = DEV_N / 2;
  localparam int D16 = DEV_N / 4;
  localparam int TW  = $clog2(CL + 24);
  localparam logic [1:0] M_BYP = 2'd0, M_X32 = 2'd1, M_X16 = 2'd2;
  localparam logic [1:0] OP_NOP = 2'd0, OP_RD = 2'd2, OP_WR = 2'd3;

  function automatic logic [TW-1:0] dcyc(input logic [1:0] m);
    case (m)
      M_X32:   return TW'(8);
      M_X16:   return TW'(16);
      default: return TW'(4);
    endcase
  endfunction

  function automatic logic [DEV_N-1:0] sel_mask(input logic [1:0] m, input logic [1:0] r);
    logic [DEV_N-1:0] h, q;
    h = DEV_N'({D32{1'b1}});
    q = DEV_N'({D16{1'b1}});
    case (m)
      M_X32:   return h << (r[0] * D32);
      M_X16:   return q << (r * D16);
      default: return '1;
    endcase
  endfunction

  logic [1:0] md;
  logic       cmd_hit, rd_go, wr_go;
  assign md        = (cfg_mode == 2'd3) ? M_BYP : cfg_mode;
  assign cmd_hit   = (cmd_op != OP_NOP) && (cmd_rank == RANK_ID);

  logic          rd_act, wr_act;
  logic [TW-1:0] rd_t, wr_t;
  logic [1:0]    rd_md, rd_mr, wr_md, wr_mr;
  logic [LW-1:0] rbuf, wbuf;

  assign proto_err = cmd_hit && ((cmd_op == OP_RD && rd_act) || (cmd_op == OP_WR && wr_act));
  assign rd_go     = cmd_hit && cmd_op == OP_RD && !rd_act;
  assign wr_go     = cmd_hit && cmd_op == OP_WR && !wr_act;
  assign dev_cs    = (cmd_hit && !proto_err) ? sel_mask(md, cmd_mr) : '0;

  logic [TW-1:0] rd_end, rd_first, rj;
  logic [1:0]    rbeat;
  logic          rd_cap;
  assign rd_end      = TW'(CL) + dcyc(rd_md);
  assign rd_first    = rd_end - TW'(3);
  assign rj          = rd_t - TW'(CL);
  assign rd_cap      = rd_act && rd_t >= TW'(CL) && rd_t < rd_end;
  assign host_rvalid = rd_act && rd_t >= rd_first;
  assign rbeat       = 2'(rd_t - rd_first);
  assign host_rdq    = host_rvalid ? rbuf[rbeat*HW +: HW] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act <= 1'b0;
      rd_t   <= '0;
      rd_md  <= M_BYP;
      rd_mr  <= '0;
      rbuf   <= '0;
    end else begin
      if (rd_go) begin
        rd_act <= 1'b1;
        rd_t   <= TW'(1);
        rd_md  <= md;
        rd_mr  <= cmd_mr;
      end else if (rd_act) begin
        if (rd_t == rd_end) rd_act <= 1'b0;
        rd_t <= rd_t + TW'(1);
      end
      if (rd_cap) begin
        case (rd_md)
          M_X32:   rbuf[rj*W32 +: W32] <= dev_rdq[rd_mr[0]*W32 +: W32];
          M_X16:   rbuf[rj*W16 +: W16] <= dev_rdq[rd_mr*W16 +: W16];
          default: rbuf[rj*HW +: HW]   <= dev_rdq;
        endcase
      end
    end
  end

  logic [TW-1:0] wr_end, wj;
  logic [1:0]    hb;
  logic          wr_cap, wr_drv;
  assign wr_end = TW'(CL) + dcyc(wr_md);
  assign wj     = wr_t - TW'(CL + 1);
  assign hb     = 2'(wr_t - TW'(CL));
  assign wr_cap = wr_act && wr_t >= TW'(CL) && wr_t < TW'(CL + 4);
  assign wr_drv = wr_act && wr_t >= TW'(CL + 1);
  assign dev_wen = wr_drv ? sel_mask(wr_md, wr_mr) : '0;

  always_comb begin
    dev_wdq = '0;
    if (wr_drv) begin
      case (wr_md)
        M_X32:   dev_wdq[wr_mr[0]*W32 +: W32] = wbuf[wj*W32 +: W32];
        M_X16:   dev_wdq[wr_mr*W16 +: W16]    = wbuf[wj*W16 +: W16];
        default: dev_wdq                      = wbuf[wj*HW +: HW];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act <= 1'b0;
      wr_t   <= '0;
      wr_md  <= M_BYP;
      wr_mr  <= '0;
      wbuf   <= '0;
    end else begin
      if (wr_go) begin
        wr_act <= 1'b1;
        wr_t   <= TW'(1);
        wr_md  <= md;
        wr_mr  <= cmd_mr;
      end else if (wr_act) begin
        if (wr_t == wr_end) wr_act <= 1'b0;
        wr_t <= wr_t + TW'(1);
      end
      if (wr_cap) wbuf[hb*HW +: HW] <= host_wdq;
    end
  end
endmodule

// File: rtl/mrank_bridge_chk.sv
module mrank_bridge_chk #(
  parameter int DEV_N = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cmd_op,
  input logic             host_rvalid,
  input logic [DEV_N-1:0] dev_wen,
  input logic [DEV_N-1:0] dev_cs,
  input logic             proto_err
);
  logic [2:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else        run <= host_rvalid ? ((run == 3'd7) ? run : run + 3'd1) : 3'd0;
  end

  a_r10_refused_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> dev_cs == '0);

  a_r3_cs_group: assert property (@(posedge clk) disable iff (!rst_n)
    dev_cs != '0 |-> ($countones(dev_cs) == DEV_N || $countones(dev_cs) == DEV_N/2
                      || $countones(dev_cs) == DEV_N/4));

  a_r8_wen_group: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wen != '0 |-> ($countones(dev_wen) == DEV_N || $countones(dev_wen) == DEV_N/2
                       || $countones(dev_wen) == DEV_N/4));

  a_r4_no_early_data: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'd2 && dev_cs != '0) |=> !host_rvalid);

  a_r5_four_beats_max: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> run < 3'd4);

  a_r5_burst_continues: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_rvalid) |=> host_rvalid);
endmodule

bind mrank_bridge mrank_bridge_chk #(.DEV_N(DEV_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .host_rvalid(host_rvalid),
  .dev_wen(dev_wen), .dev_cs(dev_cs), .proto_err(proto_err)
);

// File: tb/mrank_bridge_tb.sv
module mrank_bridge_tb;
  localparam int DEV_N = 8, DEV_W = 16, CL = 4;
  localparam int HW = DEV_N * DEV_W, LW = 4 * HW;

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_mode = 0, cmd_op = 0, cmd_mr = 0;
  logic [0:0] cmd_rank = 0;
  logic [HW-1:0] host_wdq = 0, dev_rdq = 0, host_rdq, dev_wdq;
  logic host_rvalid, proto_err;
  logic [DEV_N-1:0] dev_wen, dev_cs;

  mrank_bridge #(.DEV_N(DEV_N), .DEV_W(DEV_W), .CL(CL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cmd_op(cmd_op), .cmd_rank(cmd_rank),
    .cmd_mr(cmd_mr), .host_wdq(host_wdq), .host_rdq(host_rdq), .host_rvalid(host_rvalid),
    .dev_rdq(dev_rdq), .dev_wdq(dev_wdq), .dev_wen(dev_wen), .dev_cs(dev_cs),
    .proto_err(proto_err));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, seed = 1;
  bit done = 0;
  logic [1:0] cfg = 0;
  bit rd_on = 0, wr_on = 0;
  int rd_s, wr_s;
  logic [1:0] rd_m, rd_mr, wr_m, wr_mr;
  logic [LW-1:0] rd_L, wr_L;

  task automatic chk(input bit ok, input string tag, input logic [HW-1:0] act, input logic [HW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  function automatic int dcyc(input logic [1:0] m);
    return (m == 2'd1) ? 8 : (m == 2'd2) ? 16 : 4;
  endfunction
  function automatic int swid(input logic [1:0] m);
    return (m == 2'd1) ? HW/2 : (m == 2'd2) ? HW/4 : HW;
  endfunction
  function automatic int loff(input logic [1:0] m, input logic [1:0] r);
    return (m == 2'd1) ? r[0]*(HW/2) : (m == 2'd2) ? r*(HW/4) : 0;
  endfunction
  function automatic logic [DEV_N-1:0] msk(input logic [1:0] m, input logic [1:0] r);
    return (m == 2'd1) ? (8'h0F << (r[0]*4)) : (m == 2'd2) ? (8'h03 << (r*2)) : 8'hFF;
  endfunction
  function automatic logic [LW-1:0] mkline(input int s);
    logic [LW-1:0] l;
    for (int i = 0; i < LW/32; i++) l[i*32 +: 32] = (32'h9E3779B9 * (i + 1)) ^ (s * 32'h01010101);
    return l;
  endfunction
  function automatic logic [HW-1:0] place(input logic [HW-1:0] base, input logic [LW-1:0] l,
                                          input int j, input logic [1:0] m, input logic [1:0] r);
    logic [LW-1:0] mk, sl, lm;
    mk = (LW'(1) << swid(m)) - 1;
    sl = (l >> (j * swid(m))) & mk;
    lm = mk << loff(m, r);
    return (base & ~HW'(lm)) | HW'(sl << loff(m, r));
  endfunction

  task automatic tick(input logic [1:0] op, input logic [1:0] mr, input logic rk);
    int d;
    logic [1:0] em;
    bit hit, eerr, erv;
    logic [DEV_N-1:0] ecs, ewen;
    logic [HW-1:0] erq, ewdq;
    string tg;
    @(negedge clk);
    cyc++;
    if (rd_on && cyc - rd_s > CL + dcyc(rd_m)) rd_on = 0;
    if (wr_on && cyc - wr_s > CL + dcyc(wr_m)) wr_on = 0;
    em = (cfg == 2'd3) ? 2'd0 : cfg;
    cfg_mode = cfg; cmd_op = op; cmd_mr = mr; cmd_rank = rk;
    dev_rdq = {(HW/32){32'hC3C33C3C}};
    if (rd_on) begin
      d = cyc - rd_s;
      if (d >= CL && d < CL + dcyc(rd_m)) dev_rdq = place(dev_rdq, rd_L, d - CL, rd_m, rd_mr);
    end
    host_wdq = {(HW/32){32'h0F0F7E7E}};
    if (wr_on) begin
      d = cyc - wr_s;
      if (d >= CL && d < CL + 4) host_wdq = HW'(wr_L >> ((d - CL) * HW));
    end
    hit  = (op != 2'd0) && (rk == 1'b0);
    eerr = hit && ((op == 2'd2 && rd_on && cyc > rd_s) || (op == 2'd3 && wr_on && cyc > wr_s));
    ecs  = (hit && !eerr) ? msk(em, mr) : '0;
    #2;
    chk(dev_cs === ecs, "R2/R3 chip select", HW'(dev_cs), HW'(ecs));
    chk(proto_err === eerr, "R10 protocol error", HW'(proto_err), HW'(eerr));
    erv = 0; erq = '0; tg = "R7 bypass read";
    if (rd_on) begin
      d = cyc - rd_s;
      tg = (rd_m == 2'd1) ? "R4/R5 half read" : (rd_m == 2'd2) ? "R4/R6 quarter read" : "R4/R7 bypass read";
      if (d >= CL + dcyc(rd_m) - 3 && d <= CL + dcyc(rd_m)) begin
        erv = 1;
        erq = HW'(rd_L >> ((d - (CL + dcyc(rd_m) - 3)) * HW));
      end
    end
    chk(host_rvalid === erv && host_rdq === erq, tg, host_rdq, erq);
    ewen = '0; ewdq = '0;
    if (wr_on) begin
      d = cyc - wr_s;
      if (d >= CL + 1 && d <= CL + dcyc(wr_m)) begin
        ewen = msk(wr_m, wr_mr);
        ewdq = place('0, wr_L, d - CL - 1, wr_m, wr_mr);
      end
    end
    chk(dev_wen === ewen && dev_wdq === ewdq, "R8 write lanes", dev_wdq, ewdq);
    if (hit && !eerr && op == 2'd2) begin
      rd_on = 1; rd_s = cyc; rd_m = em; rd_mr = mr; rd_L = mkline(seed); seed++;
    end
    if (hit && !eerr && op == 2'd3) begin
      wr_on = 1; wr_s = cyc; wr_m = em; wr_mr = mr; wr_L = mkline(seed); seed++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(2'd0, 2'd0, 1'b0);
  endtask

  // {op, mode, mr, rank}
  localparam int NV = 14;
  localparam logic [6:0] VEC [NV] = '{
    {2'd2, 2'd0, 2'd0, 1'b0}, {2'd2, 2'd1, 2'd0, 1'b0}, {2'd2, 2'd1, 2'd1, 1'b0},
    {2'd2, 2'd2, 2'd0, 1'b0}, {2'd2, 2'd2, 2'd3, 1'b0}, {2'd2, 2'd2, 2'd2, 1'b0},
    {2'd3, 2'd0, 2'd0, 1'b0}, {2'd3, 2'd1, 2'd1, 1'b0}, {2'd3, 2'd2, 2'd1, 1'b0},
    {2'd3, 2'd2, 2'd2, 1'b0}, {2'd2, 2'd3, 2'd0, 1'b0}, {2'd2, 2'd1, 2'd0, 1'b1},
    {2'd3, 2'd1, 2'd2, 1'b0}, {2'd1, 2'd2, 2'd1, 1'b0}};

  initial begin
    // R1: quiet outputs while in reset and just after it
    repeat (3) begin
      @(negedge clk); #2;
      chk(host_rvalid === 0 && host_rdq === '0, "R1 reset read side", host_rdq, '0);
      chk(dev_wen === '0 && dev_wdq === '0 && dev_cs === '0 && proto_err === 0,
          "R1 reset device side", dev_wdq, '0);
    end
    rst_n = 1;
    idle(2);

    // table walk: every split, several mini-ranks, R2 rank mismatch and activate
    for (int v = 0; v < NV; v++) begin
      cfg = VEC[v][4:3];
      tick(VEC[v][6:5], VEC[v][2:1], VEC[v][0]);
      idle(CL + 20);
    end

    // R10: same-direction command while busy, including on the last beat
    cfg = 2'd1;
    tick(2'd2, 2'd0, 1'b0);
    idle(2);
    tick(2'd2, 2'd1, 1'b0);
    idle(CL + 8 - 4);
    tick(2'd2, 2'd1, 1'b0);
    tick(2'd2, 2'd1, 1'b0);
    idle(CL + 12);
    tick(2'd3, 2'd0, 1'b0);
    idle(3);
    tick(2'd3, 2'd1, 1'b0);
    idle(CL + 12);

    // R9: read and write overlapping on different mini-ranks
    cfg = 2'd2;
    tick(2'd2, 2'd0, 1'b0);
    tick(2'd3, 2'd3, 1'b0);
    idle(CL + 22);
    cfg = 2'd1;
    tick(2'd3, 2'd0, 1'b0);
    tick(2'd2, 2'd1, 1'b0);
    idle(CL + 14);

    // R11: split changed during a burst
    cfg = 2'd2;
    tick(2'd2, 2'd1, 1'b0);
    tick(2'd3, 2'd2, 1'b0);
    cfg = 2'd0;
    idle(3);
    cfg = 2'd1;
    idle(CL + 20);

    // R1: reset in the middle of a burst
    cfg = 2'd1;
    tick(2'd2, 2'd0, 1'b0);
    idle(CL + 2);
    @(negedge clk);
    rst_n = 0;
    rd_on = 0; wr_on = 0;
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); #2;
      chk(host_rvalid === 0 && host_rdq === '0, "R1 reset mid-burst", host_rdq, '0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule